// File: doc/BRIEF.md
# Multi-Port Broadcast Register Write

This block holds a register file that is copied across up to four identical ports. It also holds one global register space and one test register space, and it decodes a single shared address bus to steer writes and reads among them. A broadcast mode bit sits in the global control register. When that bit is set, a write aimed at any populated port is applied to the same offset in every populated port in the same cycle. This lets software configure all ports with one access per register.

The number of populated ports comes from a 3-bit strap input, which is captured while reset is held. Ports above that count behave as absent: they are never written, and reads of them return zero with an invalid flag. While broadcast is on, per-port read data is meaningless and is reported as invalid. Global and test reads keep returning real data.

Top module: `mpbw_regfile`

## Requirements
- R1: After reset the broadcast bit is 0, every stored register reads 0, and `rdata`, `rd_valid` and `rd_invalid` are 0.
- R2: The address is split into a region in bits [6:4] and an offset in bits [3:0]. Regions 0 to 3 select port 0 to 3, region 4 is global space and region 5 is test space. Global offset 0 is the control register: bit 0 is the broadcast enable and its other bits read 0. With broadcast off, a write to a populated port changes only that port.
- R3: With broadcast on, a write to any populated port's offset stores the same data at that offset in every populated port.
- R4: A port at or above the populated count is never written. A write addressed to such a port is dropped in either mode, and it leaves all other ports unchanged.
- R5: With broadcast on, a read of any port region returns 0 with `rd_invalid` = 1.
- R6: With broadcast on, reads of global and test registers return the stored data with `rd_invalid` = 0.
- R7: A read issued with `rd_en` at a clock edge gives `rdata` and `rd_valid` = 1 after that edge, and only then. A write to the same register in the same cycle is not visible to that read.
- R8: `strap_ports` is sampled while `rst_n` is low. A value of 0 counts as 1 and a value above 4 counts as 4. A read of an absent port, or of region 6 or 7, returns 0 with `rd_invalid` = 1.
- R9: `bcast_on` equals the control bit and changes in the cycle after the write to the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps are captured while low |
| strap_ports | input | 3 | Number of populated ports |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Region [6:4], offset [3:0] |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rd_valid | output | 1 | Read response present |
| rd_invalid | output | 1 | Read data is not meaningful |
| bcast_on | output | 1 | Broadcast mode bit |

## Verification
The assertions watch the internal per-port write strobes on every cycle. They check that an absent port never gets a strobe, that broadcast strobes cover exactly the populated set, and that without broadcast at most one port is struck. They also check that port reads under broadcast come back blanked and flagged, and that the read response appears exactly one cycle after the request. Only the bench scenarios can show that stored data lands at the right offset and survives later accesses. The same holds for the strap clamping, for dropped writes to absent ports leaving other ports intact, and for a same-cycle write being invisible to its read.

// File: rtl/mpbw_pkg.sv
package mpbw_pkg;

  localparam int unsigned REGION_W   = 3;
  localparam logic [REGION_W-1:0] GLB_REGION = 3'd4;
  localparam logic [REGION_W-1:0] TST_REGION = 3'd5;

  // Clamp the strap count into 1..maxp
  function automatic logic [2:0] clamp_ports(input logic [2:0] s, input int unsigned maxp);
    logic [2:0] r;
    if (s == 3'd0)                r = 3'd1;
    else if (int'(s) > int'(maxp)) r = 3'(maxp);
    else                          r = s;
    return r;
  endfunction

  // True when region code names port p
  function automatic logic is_port_region(input logic [REGION_W-1:0] r, input int unsigned p);
    return r == REGION_W'(p);
  endfunction

endpackage

// File: rtl/mpbw_bank.sv
module mpbw_bank #(
  parameter int unsigned DW    = 16,
  parameter int unsigned OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [OFF_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [OFF_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam int unsigned DEPTH = 1 << OFF_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mpbw_decode.sv
module mpbw_decode
  import mpbw_pkg::*;
#(
  parameter int unsigned NP     = 4,
  parameter int unsigned OFF_W  = 4,
  parameter int unsigned ADDR_W = REGION_W + OFF_W
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bcast,
  input  logic [NP-1:0]     vmask,
  output logic [NP-1:0]     port_we,
  output logic              glb_we,
  output logic              tst_we,
  output logic              ctrl_we
);
  logic [REGION_W-1:0] region;
  logic [OFF_W-1:0]    off;
  logic                tgt_present;

  assign region = addr[ADDR_W-1:OFF_W];
  assign off    = addr[OFF_W-1:0];

  always_comb begin
    tgt_present = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (is_port_region(region, p) && vmask[p]) tgt_present = 1'b1;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_we
    if (p == 0) begin : g_first
      // port 0 is always populated
      assign port_we[p] = wr_en && tgt_present && (bcast || is_port_region(region, p));
    end else begin : g_rest
      assign port_we[p] = wr_en && tgt_present && vmask[p] &&
                          (bcast || is_port_region(region, p));
    end
  end

  assign glb_we  = wr_en && (region == GLB_REGION);
  assign tst_we  = wr_en && (region == TST_REGION);
  assign ctrl_we = glb_we && (off == '0);
endmodule

// File: rtl/mpbw_rdmux.sv
module mpbw_rdmux
  import mpbw_pkg::*;
#(
  parameter int unsigned NP = 4,
  parameter int unsigned DW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en,
  input  logic [REGION_W-1:0]    region,
  input  logic                   off_zero,
  input  logic                   bcast,
  input  logic [NP-1:0]          vmask,
  input  logic [NP-1:0][DW-1:0]  port_rdata,
  input  logic [DW-1:0]          glb_rdata,
  input  logic [DW-1:0]          tst_rdata,
  output logic [DW-1:0]          rdata,
  output logic                   rd_valid,
  output logic                   rd_invalid
);
  logic [DW-1:0] nxt_d;
  logic          nxt_inv;

  always_comb begin
    nxt_d   = '0;
    nxt_inv = 1'b1;
    for (int p = 0; p < NP; p++) begin
      if (is_port_region(region, p) && vmask[p] && !bcast) begin
        nxt_d   = port_rdata[p];
        nxt_inv = 1'b0;
      end
    end
    if (region == GLB_REGION) begin
      nxt_inv = 1'b0;
      nxt_d   = off_zero ? {{(DW-1){1'b0}}, bcast} : glb_rdata;
    end
    if (region == TST_REGION) begin
      nxt_inv = 1'b0;
      nxt_d   = tst_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata      <= '0;
      rd_valid   <= 1'b0;
      rd_invalid <= 1'b0;
    end else begin
      rd_valid   <= rd_en;
      rdata      <= rd_en ? nxt_d : '0;
      rd_invalid <= rd_en && nxt_inv;
    end
  end
endmodule

// File: rtl/mpbw_regfile.sv
module mpbw_regfile
  import mpbw_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned OFF_W     = 4,
  parameter int unsigned ADDR_W    = REGION_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        strap_ports,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              rd_invalid,
  output logic              bcast_on
);
  logic [2:0]                        cnt_q;
  logic [NUM_PORTS-1:0]              vmask;
  logic                              bcast_q;
  logic [NUM_PORTS-1:0]              port_we;
  logic                              glb_we;
  logic                              tst_we;
  logic                              ctrl_we;
  logic [OFF_W-1:0]                  off;
  logic [NUM_PORTS-1:0][DATA_W-1:0]  port_rdata;
  logic [DATA_W-1:0]                 glb_rdata;
  logic [DATA_W-1:0]                 tst_rdata;

  assign off = addr[OFF_W-1:0];

  // Strap capture: loads every cycle while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= clamp_ports(strap_ports, NUM_PORTS);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mask
    assign vmask[p] = cnt_q > 3'(p);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bcast_q <= 1'b0;
    else if (ctrl_we) bcast_q <= wdata[0];
  end
  assign bcast_on = bcast_q;

  mpbw_decode #(.NP(NUM_PORTS), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) dec_i (
    .wr_en  (wr_en),
    .addr   (addr),
    .bcast  (bcast_q),
    .vmask  (vmask),
    .port_we(port_we),
    .glb_we (glb_we),
    .tst_we (tst_we),
    .ctrl_we(ctrl_we)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    mpbw_bank #(.DW(DATA_W), .OFF_W(OFF_W)) bank_i (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (port_we[p]),
      .waddr(off),
      .wdata(wdata),
      .raddr(off),
      .rdata(port_rdata[p])
    );
  end

  mpbw_bank #(.DW(DATA_W), .OFF_W(OFF_W)) glb_bank_i (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (glb_we),
    .waddr(off),
    .wdata(wdata),
    .raddr(off),
    .rdata(glb_rdata)
  );

  mpbw_bank #(.DW(DATA_W), .OFF_W(OFF_W)) tst_bank_i (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (tst_we),
    .waddr(off),
    .wdata(wdata),
    .raddr(off),
    .rdata(tst_rdata)
  );

  mpbw_rdmux #(.NP(NUM_PORTS), .DW(DATA_W)) rdm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .region    (addr[ADDR_W-1:OFF_W]),
    .off_zero  (off == '0),
    .bcast     (bcast_q),
    .vmask     (vmask),
    .port_rdata(port_rdata),
    .glb_rdata (glb_rdata),
    .tst_rdata (tst_rdata),
    .rdata     (rdata),
    .rd_valid  (rd_valid),
    .rd_invalid(rd_invalid)
  );
endmodule

// File: rtl/mpbw_chk.sv
module mpbw_chk #(
  parameter int unsigned NP     = 4,
  parameter int unsigned DW     = 16,
  parameter int unsigned OFF_W  = 4,
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NP-1:0]     port_we,
  input logic [NP-1:0]     vmask,
  input logic              bcast,
  input logic [DW-1:0]     rdata,
  input logic              rd_valid,
  input logic              rd_invalid
);
  localparam int unsigned RW = ADDR_W - OFF_W;
  logic rd_port;
  assign rd_port = rd_en && (addr[ADDR_W-1:OFF_W] < RW'(NP));

  // R4
  no_absent_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_we & ~vmask) == '0);

  // R3
  bcast_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast && (|port_we)) |-> (port_we == vmask));

  // R2
  single_port_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bcast |-> $onehot0(port_we));

  // R5
  bcast_rd_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_port && bcast) |=> (rd_invalid && rdata == '0));

  // R7
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R7
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R8
  port0_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vmask[0]);
endmodule

bind mpbw_regfile mpbw_chk #(
  .NP(NUM_PORTS), .DW(DATA_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .addr      (addr),
  .port_we   (port_we),
  .vmask     (vmask),
  .bcast     (bcast_q),
  .rdata     (rdata),
  .rd_valid  (rd_valid),
  .rd_invalid(rd_invalid)
);

// File: tb/mpbw_regfile_tb_top.sv
`timescale 1ns/1ps
module mpbw_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  strap_ports = 3'd3;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rd_valid;
  logic        rd_invalid;
  logic        bcast_on;

  always #10 clk = ~clk;

  mpbw_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .strap_ports(strap_ports),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid), .rd_invalid(rd_invalid),
    .bcast_on(bcast_on)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // Reference model written from the requirements
  logic [15:0] port_m [4][16];
  logic [15:0] glb_m [16];
  logic [15:0] tst_m [16];
  logic        bcast_m;
  int          cnt_m;

  logic [15:0] exp_d_q [$];
  logic        exp_i_q [$];
  string       exp_r_q [$];

  function automatic logic [6:0] ad(input int r, input int o);
    return {r[2:0], o[3:0]};
  endfunction

  task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic model_clear(input logic [2:0] s);
    for (int p = 0; p < 4; p++) for (int o = 0; o < 16; o++) port_m[p][o] = '0;
    for (int o = 0; o < 16; o++) begin glb_m[o] = '0; tst_m[o] = '0; end
    bcast_m = 1'b0;
    cnt_m = (s == 0) ? 1 : ((s > 4) ? 4 : int'(s));
  endtask

  task automatic do_reset(input logic [2:0] s);
    @(negedge clk);
    rst_n = 1'b0; strap_ports = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear(s);
    // R1 reset state of outputs
    check("R1 rdata", rdata, 16'h0);
    check("R1 rd_valid", {15'b0, rd_valid}, 16'h0);
    check("R1 bcast_on", {15'b0, bcast_on}, 16'h0);
  endtask

  task automatic acc(input bit we, input bit re, input logic [6:0] a,
                     input logic [15:0] d, input string rq);
    int r, o;
    logic [15:0] ed;
    logic ei;
    r = int'(a[6:4]); o = int'(a[3:0]);
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wdata = d;
    if (re) begin
      ed = '0; ei = 1'b1;
      if (r < 4) begin
        if (r < cnt_m && !bcast_m) begin ed = port_m[r][o]; ei = 1'b0; end
      end else if (r == 4) begin
        ei = 1'b0; ed = (o == 0) ? {15'b0, bcast_m} : glb_m[o];
      end else if (r == 5) begin
        ei = 1'b0; ed = tst_m[o];
      end
      exp_d_q.push_back(ed); exp_i_q.push_back(ei); exp_r_q.push_back(rq);
    end
    if (we) begin
      if (r < 4 && r < cnt_m) begin
        if (bcast_m) begin
          for (int p = 0; p < cnt_m; p++) port_m[p][o] = d;
        end else port_m[r][o] = d;
      end else if (r == 4) begin
        glb_m[o] = d;
        if (o == 0) bcast_m = d[0];
      end else if (r == 5) tst_m[o] = d;
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    acc(1'b1, 1'b0, a, d, "");
  endtask

  task automatic rd(input logic [6:0] a, input string rq);
    acc(1'b0, 1'b1, a, 16'h0, rq);
  endtask

  // Monitor: pop expected items as responses appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_d_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R7 unexpected response: actual %h expected none", rdata);
      end else begin
        automatic logic [15:0] ed = exp_d_q.pop_front();
        automatic logic        ei = exp_i_q.pop_front();
        automatic string       rq = exp_r_q.pop_front();
        check({rq, " data"}, rdata, ed);
        check({rq, " invalid"}, {15'b0, rd_invalid}, {15'b0, ei});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(3'd3);
    rd(ad(4, 0), "R1 ctrl after reset");
    rd(ad(0, 2), "R1 port reg after reset");
    // R2 single-port write
    wr(ad(1, 5), 16'h1111);
    rd(ad(1, 5), "R2 own port");
    rd(ad(0, 5), "R2 other port0");
    rd(ad(2, 5), "R2 other port2");
    // R8 absent port and unmapped region
    wr(ad(3, 5), 16'h3333);
    rd(ad(3, 5), "R8 absent port read");
    rd(ad(6, 1), "R8 unmapped region");
    // R7 same-cycle write and read
    wr(ad(0, 3), 16'hAAAA);
    acc(1'b1, 1'b1, ad(0, 3), 16'hBBBB, "R7 old data on same cycle");
    rd(ad(0, 3), "R7 new data later");
    // R9 mode bit
    wr(ad(4, 0), 16'h0001);
    check("R9 bcast_on set", {15'b0, bcast_on}, {15'b0, bcast_m});
    wr(ad(2, 7), 16'hC0DE);                  // R3 broadcast write
    rd(ad(2, 7), "R5 port read blanked");
    rd(ad(0, 3), "R5 port0 read blanked");
    wr(ad(5, 2), 16'h7357);
    rd(ad(5, 2), "R6 test read");
    rd(ad(4, 0), "R6 ctrl read");
    wr(ad(4, 9), 16'h1234);
    rd(ad(4, 9), "R6 global read");
    wr(ad(3, 3), 16'hDEAD);                  // R4 broadcast to absent port
    wr(ad(4, 0), 16'hFFFE);
    check("R9 bcast_on clear", {15'b0, bcast_on}, 16'h0);
    rd(ad(4, 0), "R2 ctrl upper bits zero");
    rd(ad(0, 7), "R3 port0 got broadcast");
    rd(ad(1, 7), "R3 port1 got broadcast");
    rd(ad(2, 7), "R3 port2 got broadcast");
    rd(ad(0, 3), "R4 port0 untouched");
    rd(ad(1, 5), "R4 port1 untouched");
    // R8 strap 0 counts as one port
    do_reset(3'd0);
    rd(ad(0, 1), "R1 cleared by reset");
    wr(ad(4, 0), 16'h0001);
    wr(ad(0, 1), 16'h5555);
    wr(ad(4, 0), 16'h0000);
    rd(ad(0, 1), "R3 single port broadcast");
    rd(ad(1, 1), "R8 port1 absent with strap 0");
    // R8 strap 7 counts as four ports
    do_reset(3'd7);
    wr(ad(4, 0), 16'h0001);
    wr(ad(3, 4), 16'h4444);
    wr(ad(4, 0), 16'h0000);
    for (int p = 0; p < 4; p++) rd(ad(p, 4), "R3 four-port broadcast");
    repeat (3) @(negedge clk);
    check("R7 no pending responses", 16'(exp_d_q.size()), 16'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule